// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block sits between a processor-side register bus and the serial shifters of a small UART. It holds a transmit queue and a receive queue, a write-only control word and a read-only status word, and it turns receiver error pulses into sticky status flags. It also raises an interrupt pulse when the receive queue first fills or the transmit queue drains.

The register bus is a plain 32-bit request/acknowledge port. Every request is answered exactly one clock later, with an error flag for illegal accesses. The receiver delivers characters with per-character error qualifiers. The transmitter takes characters through a valid/ready handshake. Baud timing and serial framing live outside this block.

Top module: `uart_regif`

## Requirements
- R1: Every cycle with `bus_req` high is answered in the following cycle by `bus_ack` high, together with `bus_err` and `bus_rdata` for that request; `bus_ack` is low in all other cycles.
- R2: Each queue holds 16 characters. A write to the transmit word (offset 0x4) while that queue is full is acknowledged without error, and the character is discarded.
- R3: `tx_valid` is high whenever the transmit queue is not empty. `tx_data` presents the oldest queued character. A cycle with `tx_valid` and `tx_ready` both high removes that character, so characters leave in the order they were written.
- R4: A read of offset 0x0 returns the oldest received character in bits 7:0, with zeros above, and removes it from the queue. A read of offset 0x0 while the receive queue is empty returns `bus_err` with zero data.
- R5: A request with `bus_be` other than 4'b1111, or with address bits 1:0 not zero, returns `bus_err` with zero data and changes no state.
- R6: A write to offset 0x0 or 0x8 is acknowledged and changes nothing. A read of offset 0x4 or 0xC is acknowledged and returns zero.
- R7: The status word at offset 0x8 carries, from bit 0 upward: receive data present, receive full, transmit empty, transmit full, interrupt enabled, overrun, frame error, parity error. Bits 31:8 are zero. After reset it reads 0x04.
- R8: A write to offset 0xC with bit 0 set empties the transmit queue, and with bit 1 set empties the receive queue. Bit 4 of that write becomes the interrupt-enable setting.
- R9: A received character flagged with `rx_frame_err` is discarded and sets the frame flag. An unflagged character that arrives while the receive queue is full is discarded and sets the overrun flag. A character flagged with `rx_parity_err` that is accepted is stored and sets the parity flag.
- R10: The overrun, frame and parity flags stay set until a status read. A status read returns their value and then clears them, except that an event arriving in the same cycle as the read leaves its flag set for the next read.
- R11: With interrupts enabled, `irq` pulses high for one cycle, in the cycle after the clock edge at which either the receive queue goes from empty to non-empty or the transmit queue goes from non-empty to empty (a clear included). With interrupts disabled, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the register window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is legal |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Error response, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| rx_valid | input | 1 | Receiver delivers a character this cycle |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Character had a bad stop bit |
| rx_parity_err | input | 1 | Character had a parity mismatch |
| tx_valid | output | 1 | A character is waiting for the transmitter |
| tx_data | output | 8 | Oldest waiting character |
| tx_ready | input | 1 | Transmitter takes the character this cycle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Bus responses arrive exactly one clock after the request edge. Queue, flag and status changes are visible right after that same edge. `irq` is high during the cycle that follows the edge that emptied or filled a queue. The bench drives every input just after a falling edge and samples at the next falling edge, which is half a clock after the edge that produced the result, so each response and handshake output is read in the one cycle where it is due. Interrupt pulses are counted on falling edges by a separate process. That count is compared against the bench model only after an idle cycle, so a pulse from the last operation has already been counted.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int BUS_W = 32;
  localparam int BE_W  = BUS_W / 8;

  // word index within the register window (address bits 3:2)
  localparam logic [1:0] W_RXD  = 2'd0;
  localparam logic [1:0] W_TXD  = 2'd1;
  localparam logic [1:0] W_STAT = 2'd2;
  localparam logic [1:0] W_CTRL = 2'd3;

  // control write bit positions
  localparam int CB_TXCLR = 0;
  localparam int CB_RXCLR = 1;
  localparam int CB_IE    = 4;

  // packed so that rx_avail lands on bit 0
  typedef struct packed {
    logic par_err;
    logic frm_err;
    logic ovr_err;
    logic irq_en;
    logic tx_full;
    logic tx_empty;
    logic rx_full;
    logic rx_avail;
  } stat_t;

  function automatic logic [BUS_W-1:0] pack_status(stat_t s);
    return {{(BUS_W-8){1'b0}}, s};
  endfunction

  // sticky flag: set has priority over the read-clear
  function automatic logic sticky_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [BUS_W-1:0] widen_char(logic [7:0] c);
    return {{(BUS_W-8){1'b0}}, c};
  endfunction

endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         went_nonempty,
  output logic         went_empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign cnt_d   = clr ? '0 : cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  assign dout    = mem[rd_ptr];

  assign went_nonempty = empty & (cnt_d != '0);
  assign went_empty    = ~empty & (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (do_push) wr_ptr <= ptr_inc(wr_ptr);
        if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  a_r2_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == $past(cnt_q)));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/uart_regif_events.sv
module uart_regif_events
  import uart_regif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic stat_rd,
  input  logic ovr_set,
  input  logic frm_set,
  input  logic par_set,
  input  logic rx_went_nonempty,
  input  logic tx_went_empty,
  output logic ovr_q,
  output logic frm_q,
  output logic par_q,
  output logic irq_q
);
  logic irq_event;
  assign irq_event = irq_en & (rx_went_nonempty | tx_went_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      frm_q <= 1'b0;
      par_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovr_q <= sticky_next(ovr_q, ovr_set, stat_rd);
      frm_q <= sticky_next(frm_q, frm_set, stat_rd);
      par_q <= sticky_next(par_q, par_set, stat_rd);
      irq_q <= irq_event;
    end
  end

  a_r10_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !stat_rd) |=> ovr_q);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    frm_set |=> frm_q);

  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(irq_en));

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [BE_W-1:0]  bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic             bus_ack,
  output logic             bus_err,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_frame_err,
  input  logic             rx_parity_err,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic             irq
);
  // decode
  logic [1:0] word;
  logic       misaligned, size_bad, rd_empty_err, acc_err, acc_ok;
  logic       rx_pop, tx_push, ctrl_wr, stat_rd;
  logic       tx_clr, rx_clr;
  // queue state
  logic       rx_empty, rx_full, tx_empty, tx_full;
  logic       rx_went_nonempty, tx_went_empty;
  logic [7:0] rx_head;
  // receive events
  logic       rx_accept, ovr_set, frm_set, par_set;
  logic       ovr_q, frm_q, par_q, ie_q;
  stat_t      status;
  logic [BUS_W-1:0] rd_mux;
  logic       unused_wdata;

  assign word         = bus_addr[3:2];
  assign misaligned   = |bus_addr[1:0];
  assign size_bad     = (bus_be != {BE_W{1'b1}});
  assign rd_empty_err = ~bus_we & (word == W_RXD) & rx_empty;
  assign acc_err      = misaligned | size_bad | rd_empty_err;
  assign acc_ok       = bus_req & ~acc_err;

  assign rx_pop  = acc_ok & ~bus_we & (word == W_RXD);
  assign stat_rd = acc_ok & ~bus_we & (word == W_STAT);
  assign tx_push = acc_ok &  bus_we & (word == W_TXD);
  assign ctrl_wr = acc_ok &  bus_we & (word == W_CTRL);
  assign tx_clr  = ctrl_wr & bus_wdata[CB_TXCLR];
  assign rx_clr  = ctrl_wr & bus_wdata[CB_RXCLR];
  assign unused_wdata = ^bus_wdata[BUS_W-1:8];

  assign rx_accept = rx_valid & ~rx_frame_err;
  assign frm_set   = rx_valid & rx_frame_err;
  assign ovr_set   = rx_accept & rx_full;
  assign par_set   = rx_accept & ~rx_full & rx_parity_err;

  uart_regif_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_accept), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full),
    .went_nonempty(rx_went_nonempty), .went_empty()
  );

  uart_regif_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_ready), .dout(tx_data),
    .empty(tx_empty), .full(tx_full),
    .went_nonempty(), .went_empty(tx_went_empty)
  );

  uart_regif_events u_evt (
    .clk(clk), .rst_n(rst_n), .irq_en(ie_q), .stat_rd(stat_rd),
    .ovr_set(ovr_set), .frm_set(frm_set), .par_set(par_set),
    .rx_went_nonempty(rx_went_nonempty), .tx_went_empty(tx_went_empty),
    .ovr_q(ovr_q), .frm_q(frm_q), .par_q(par_q), .irq_q(irq)
  );

  assign tx_valid = ~tx_empty;

  always_comb begin
    status          = '0;
    status.rx_avail = ~rx_empty;
    status.rx_full  = rx_full;
    status.tx_empty = tx_empty;
    status.tx_full  = tx_full;
    status.irq_en   = ie_q;
    status.ovr_err  = ovr_q;
    status.frm_err  = frm_q;
    status.par_err  = par_q;
  end

  always_comb begin
    unique case (word)
      W_RXD:   rd_mux = widen_char(rx_head);
      W_STAT:  rd_mux = pack_status(status);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
      ie_q      <= 1'b0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= bus_req & acc_err;
      bus_rdata <= (acc_ok & ~bus_we) ? rd_mux : '0;
      if (ctrl_wr) ie_q <= bus_wdata[CB_IE];
    end
  end

  a_r1_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);

  a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);

  a_r5_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_be != {BE_W{1'b1}}) |=> (bus_err && bus_rdata == '0));

  a_r4_empty_read_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 4'h0 && rx_empty) |=> bus_err);

  a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_clr) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        irq;

  int n_checks = 0, n_err = 0, irq_cnt = 0, exp_irq = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit m_ie, m_ovr, m_frm, m_par;

  always #4 clk = ~clk;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {24'b0, m_par, m_frm, m_ovr, m_ie, txq.size() == 16,
            txq.size() == 0, rxq.size() == 16, rxq.size() != 0};
  endfunction

  function automatic void note_irq(int rx_before, int tx_before, bit ie);
    if (ie && ((rx_before == 0 && rxq.size() != 0) ||
               (tx_before != 0 && txq.size() == 0))) exp_irq++;
  endfunction

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic bus(input bit we, input logic [3:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic er, output logic ak);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    rd = bus_rdata; er = bus_err; ak = bus_ack;
  endtask

  // legal accesses, each checked against the model
  task automatic read_status();
    logic [31:0] rd; logic er, ak;
    logic [31:0] exp;
    exp = exp_status();
    bus(1'b0, 4'h8, 4'hF, 0, rd, er, ak);
    check("R7 status", rd, exp);
    check("R1 ack", {31'b0, ak}, 1);
    m_ovr = 0; m_frm = 0; m_par = 0;
  endtask

  task automatic read_rx();
    logic [31:0] rd; logic er, ak;
    logic [31:0] exp_d; bit exp_e;
    int rb, tb;
    rb = rxq.size(); tb = txq.size();
    exp_e = (rxq.size() == 0);
    exp_d = exp_e ? 32'h0 : {24'b0, rxq[0]};
    bus(1'b0, 4'h0, 4'hF, 0, rd, er, ak);
    check("R4 rx data", rd, exp_d);
    check("R4 empty err", {31'b0, er}, {31'b0, exp_e});
    if (!exp_e) void'(rxq.pop_front());
    note_irq(rb, tb, m_ie);
  endtask

  task automatic write_tx(input logic [7:0] d);
    logic [31:0] rd; logic er, ak;
    bus(1'b1, 4'h4, 4'hF, {24'hABCDEF, d}, rd, er, ak);
    check("R2 tx write no err", {31'b0, er}, 0);
    if (txq.size() < 16) txq.push_back(d);
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    logic [31:0] rd; logic er, ak;
    int rb, tb;
    rb = rxq.size(); tb = txq.size();
    bus(1'b1, 4'hC, 4'hF, v, rd, er, ak);
    check("R8 ctrl no err", {31'b0, er}, 0);
    if (v[0]) txq.delete();
    if (v[1]) rxq.delete();
    note_irq(rb, tb, m_ie);
    m_ie = v[4];
  endtask

  function automatic void model_rx(logic [7:0] d, bit fe, bit pe);
    if (fe) m_frm = 1;
    else if (rxq.size() == 16) m_ovr = 1;
    else begin
      rxq.push_back(d);
      if (pe) m_par = 1;
    end
  endfunction

  task automatic rx_send(input logic [7:0] d, input bit fe, input bit pe);
    int rb, tb;
    rb = rxq.size(); tb = txq.size();
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    model_rx(d, fe, pe);
    note_irq(rb, tb, m_ie);
  endtask

  task automatic tx_take();
    int rb, tb;
    rb = rxq.size(); tb = txq.size();
    @(negedge clk);
    check("R3 tx_valid", {31'b0, tx_valid}, {31'b0, txq.size() != 0});
    if (txq.size() != 0) check("R3 tx_data order", {24'b0, tx_data}, {24'b0, txq[0]});
    tx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 1'b0;
    if (txq.size() != 0) void'(txq.pop_front());
    note_irq(rb, tb, m_ie);
  endtask

  task automatic check_irq(string req);
    idle();
    check(req, irq_cnt, exp_irq);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er, ak;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R7 reset state
    check("R7 reset tx_valid", {31'b0, tx_valid}, 0);
    check("R1 no ack idle", {31'b0, bus_ack}, 0);
    read_status();

    // R5 partial write ignored
    bus(1'b1, 4'h4, 4'h1, 32'h55, rd, er, ak);
    check("R5 byte write err", {31'b0, er}, 1);
    check("R5 tx untouched", {31'b0, tx_valid}, 0);
    // R5 misaligned read
    bus(1'b0, 4'h9, 4'hF, 0, rd, er, ak);
    check("R5 misaligned err", {31'b0, er}, 1);
    check("R5 zero data", rd, 0);
    // R4 empty rx read
    read_rx();

    // R6 write-only reads zero, read-only writes ignored
    write_tx(8'h3C);
    bus(1'b0, 4'h4, 4'hF, 0, rd, er, ak);
    check("R6 read tx word zero", rd, 0);
    bus(1'b0, 4'hC, 4'hF, 0, rd, er, ak);
    check("R6 read ctrl zero", rd, 0);
    bus(1'b1, 4'h8, 4'hF, 32'hFF, rd, er, ak);
    check("R6 status write no err", {31'b0, er}, 0);
    bus(1'b1, 4'h0, 4'hF, 32'hFF, rd, er, ak);
    read_status();

    // R11 tx drain raises irq when enabled
    write_ctrl(32'h10);
    tx_take();
    check_irq("R11 tx empty irq");
    read_status();

    // R2 fill tx, overflow dropped
    for (int i = 0; i < 17; i++) write_tx(8'(i + 8'h40));
    read_status();
    tx_take();
    // R8 clear tx queue -> irq
    write_ctrl(32'h11);
    check_irq("R11 clear irq");
    read_status();

    // R9 rx path: parity stored, frame dropped, overrun
    rx_send(8'hA5, 0, 1);
    check_irq("R11 rx irq");
    rx_send(8'h5A, 1, 0);
    read_status();
    read_rx();
    read_rx();
    for (int i = 0; i < 17; i++) rx_send(8'(i), 0, 0);
    read_status();
    read_status();
    // R8 clear rx
    write_ctrl(32'h02);
    read_status();
    rx_send(8'h77, 0, 0);
    check_irq("R11 gated off");

    // R10 event in same cycle as status read stays set
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'h8; bus_be = 4'hF;
    rx_valid = 1'b1; rx_frame_err = 1'b1; rx_data = 8'h11;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0; rx_frame_err = 1'b0;
    check("R10 pre-event read", bus_rdata, exp_status());
    m_frm = 1;
    read_status();
    read_status();

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: rx_send(8'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0));
        2, 3: read_rx();
        4, 5: write_tx(8'($urandom));
        6:    tx_take();
        7:    read_status();
        8:    write_ctrl({27'b0, 1'($urandom_range(0, 1)), 2'b00,
                          ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)});
        default: idle();
      endcase
      if (n % 50 == 49) check_irq("R11 random irq count");
    end
    check_irq("R11 final irq count");
    read_status();

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule